// File: doc/BRIEF.md
# CPU Status Flag Register

This block holds the eight-bit processor status word of a small eight-bit CPU. The word carries the negative, overflow, break, decimal, interrupt-disable, zero and carry flags. The instruction decoder updates it through four active-low write strobes: a full load from the internal data bus, a masked load of ALU result flags, a set or clear of chosen flags to a single value, and a negative/zero update computed from the byte on the data bus. All of them are sampled on the rising clock edge.

One control word from the decoder does several jobs. During an ALU write it is the per-flag write mask, and during a flag write it selects the flag. A read enable places the current flags on the control-word return path so the decoder can test a bit for a branch. A separate bus output enable places the whole word on the internal data bus, which is how the status is pushed to the stack. Each bidirectional path appears here as a value plus a drive qualifier. The tri-state merge sits outside the block.

Top module: `cpu_status_flags`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register becomes 0x04. Interrupt-disable (bit 2) is set and every other flag is clear.
- R2: Flag positions are N=bit 7, V=bit 6, B=bit 4, D=bit 3, I=bit 2, Z=bit 1 and C=bit 0. Bit 5 is not stored and always reads 0, even after a load whose bit 5 is 1.
- R3: With `alu_wr_n` low, each flag whose bit is 1 in `ctl_in` takes the bit at the same position of `alu_flags`. Every other flag holds. The masks in use are 0x03, 0x82, 0x83, 0xC2 and 0xC3.
- R4: With `flag_wr_n` low, every flag whose bit is 1 in `ctl_in` takes `flag_val`, and the other flags hold. A normal caller sends a one-hot mask.
- R5: With `bus_nz_n` low, N takes `bus_in[7]` and Z becomes 1 exactly when `bus_in` is 0x00. All other flags hold.
- R6: With `bus_all_n` low, all stored flags load from `bus_in` in one cycle.
- R7: When several strobes are low together, only the highest-priority one acts. The order from highest to lowest is bus-all, ALU-write, flag-write, bus-NZ.
- R8: With all four write strobes high, the register holds its value whatever `ctl_in`, `alu_flags`, `flag_val` and `bus_in` carry.
- R9: With `bus_oe_n` low, `bus_out` shows the register and `bus_drive` is 1. Otherwise `bus_out` is 0x00 and `bus_drive` is 0.
- R10: With `rd_oe_n` low, `ctl_out` shows the register and `ctl_drive` is 1. Otherwise `ctl_out` is 0x00 and `ctl_drive` is 0.
- R11: A write becomes visible on both read paths in the cycle after its clock edge. A read in the same cycle as a write shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_all_n | input | 1 | Load every flag from the data bus (active low) |
| alu_wr_n | input | 1 | Masked load from ALU result flags (active low) |
| flag_wr_n | input | 1 | Set or clear the selected flags (active low) |
| bus_nz_n | input | 1 | Update N and Z from the data bus byte (active low) |
| bus_oe_n | input | 1 | Drive the register onto the data bus (active low) |
| rd_oe_n | input | 1 | Return the flags on the control word (active low) |
| flag_val | input | 1 | Value written by a flag write |
| ctl_in | input | 8 | Control word from the decoder: mask or flag select |
| alu_flags | input | 8 | ALU result flags at the register's bit positions |
| bus_in | input | 8 | Internal data bus as seen by the register |
| ctl_out | output | 8 | Flag readback toward the decoder |
| ctl_drive | output | 1 | Asserted while `ctl_out` owns the control word |
| bus_out | output | 8 | Register value toward the data bus |
| bus_drive | output | 1 | Asserted while `bus_out` owns the data bus |

## Verification
The embedded assertions check several rules on every cycle: the reset value, holding when no strobe is low, the one-cycle full bus load, the masked ALU merge, and release of both read paths when their enables are high. Only the bench scenarios can show the following:
- the negative/zero derivation across every bus byte;
- every flag select with both values, starting from both empty and full words;
- all sixteen strobe combinations against the priority order;
- the old value appearing on a read in the same cycle as a write.

// File: rtl/cpu_status_flags_pkg.sv
package cpu_status_flags_pkg;

    localparam int FLAG_W = 8;

    localparam int POS_N = 7;
    localparam int POS_V = 6;
    localparam int POS_B = 4;
    localparam int POS_D = 3;
    localparam int POS_I = 2;
    localparam int POS_Z = 1;
    localparam int POS_C = 0;

    localparam logic [FLAG_W-1:0] LIVE_BITS =
        (FLAG_W'(1) << POS_N) | (FLAG_W'(1) << POS_V) | (FLAG_W'(1) << POS_B) |
        (FLAG_W'(1) << POS_D) | (FLAG_W'(1) << POS_I) | (FLAG_W'(1) << POS_Z) |
        (FLAG_W'(1) << POS_C);
    localparam logic [FLAG_W-1:0] RESET_WORD = FLAG_W'(1) << POS_I;
    localparam logic [FLAG_W-1:0] NZ_BITS = (FLAG_W'(1) << POS_N) | (FLAG_W'(1) << POS_Z);

    typedef enum logic [2:0] {
        UPD_HOLD,
        UPD_BUS_ALL,
        UPD_ALU,
        UPD_FLAG,
        UPD_BUS_NZ
    } upd_e;

    typedef struct packed {
        logic bus_all_n;
        logic alu_n;
        logic flag_n;
        logic nz_n;
    } strobe_t;

    function automatic logic [FLAG_W-1:0] merge_masked(
        input logic [FLAG_W-1:0] old_v,
        input logic [FLAG_W-1:0] new_v,
        input logic [FLAG_W-1:0] mask);
        return (new_v & mask) | (old_v & ~mask);
    endfunction

    function automatic logic [FLAG_W-1:0] nz_of(input logic [FLAG_W-1:0] b);
        logic [FLAG_W-1:0] r;
        r = '0;
        r[POS_N] = b[FLAG_W-1];
        r[POS_Z] = (b == '0);
        return r;
    endfunction

endpackage

// File: rtl/cpu_status_flags_select.sv
module cpu_status_flags_select
    import cpu_status_flags_pkg::*;
(
    input  strobe_t stb,
    output upd_e    op
);
    always_comb begin
        if (!stb.bus_all_n)   op = UPD_BUS_ALL;
        else if (!stb.alu_n)  op = UPD_ALU;
        else if (!stb.flag_n) op = UPD_FLAG;
        else if (!stb.nz_n)   op = UPD_BUS_NZ;
        else                  op = UPD_HOLD;
    end
endmodule

// File: rtl/cpu_status_flags_next.sv
module cpu_status_flags_next
    import cpu_status_flags_pkg::*;
#(
    parameter int W = FLAG_W
) (
    input  upd_e         op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] alu_flags,
    input  logic         flag_val,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] nxt
);
    logic [W-1:0] raw;

    always_comb begin
        case (op)
            UPD_BUS_ALL: raw = bus_in;
            UPD_ALU:     raw = merge_masked(cur, alu_flags, mask);
            UPD_FLAG:    raw = merge_masked(cur, {W{flag_val}}, mask);
            UPD_BUS_NZ:  raw = merge_masked(cur, nz_of(bus_in), NZ_BITS);
            default:     raw = cur;
        endcase
        nxt = raw & LIVE_BITS;
    end
endmodule

// File: rtl/cpu_status_flags_port.sv
module cpu_status_flags_port #(
    parameter int W = 8
) (
    input  logic         en_n,
    input  logic [W-1:0] value,
    output logic [W-1:0] out,
    output logic         drive
);
    assign drive = ~en_n;
    assign out   = en_n ? '0 : value;
endmodule

// File: rtl/cpu_status_flags.sv
module cpu_status_flags
    import cpu_status_flags_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_all_n,
    input  logic              alu_wr_n,
    input  logic              flag_wr_n,
    input  logic              bus_nz_n,
    input  logic              bus_oe_n,
    input  logic              rd_oe_n,
    input  logic              flag_val,
    input  logic [FLAG_W-1:0] ctl_in,
    input  logic [FLAG_W-1:0] alu_flags,
    input  logic [FLAG_W-1:0] bus_in,
    output logic [FLAG_W-1:0] ctl_out,
    output logic              ctl_drive,
    output logic [FLAG_W-1:0] bus_out,
    output logic              bus_drive
);
    localparam int N_PORTS = 2;

    strobe_t           stb;
    upd_e              op;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] flags_d;

    assign stb = '{bus_all_n: bus_all_n, alu_n: alu_wr_n, flag_n: flag_wr_n, nz_n: bus_nz_n};

    cpu_status_flags_select u_sel (
        .stb (stb),
        .op  (op)
    );

    cpu_status_flags_next #(.W(FLAG_W)) u_next (
        .op        (op),
        .cur       (flags_q),
        .mask      (ctl_in),
        .alu_flags (alu_flags),
        .flag_val  (flag_val),
        .bus_in    (bus_in),
        .nxt       (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) flags_q <= RESET_WORD;
        else     flags_q <= flags_d;
    end

    logic [N_PORTS-1:0]             p_en_n;
    logic [N_PORTS-1:0][FLAG_W-1:0] p_out;
    logic [N_PORTS-1:0]             p_drive;

    assign p_en_n = {bus_oe_n, rd_oe_n};

    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
        cpu_status_flags_port #(.W(FLAG_W)) u_port (
            .en_n  (p_en_n[g]),
            .value (flags_q),
            .out   (p_out[g]),
            .drive (p_drive[g])
        );
    end

    assign ctl_out   = p_out[0];
    assign ctl_drive = p_drive[0];
    assign bus_out   = p_out[1];
    assign bus_drive = p_drive[1];

    // R1
    reset_word_chk: assert property (@(posedge clk) rst |=> (flags_q == RESET_WORD));

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_all_n && alu_wr_n && flag_wr_n && bus_nz_n) |=> $stable(flags_q));

    // R6
    bus_all_load_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_all_n |=> (flags_q == ($past(bus_in) & LIVE_BITS)));

    // R3
    alu_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_all_n && !alu_wr_n) |=>
        ((flags_q & $past(ctl_in)) == ($past(alu_flags) & $past(ctl_in) & LIVE_BITS)) &&
        ((flags_q & ~$past(ctl_in)) == ($past(flags_q) & ~$past(ctl_in))));

    // R9
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe_n |-> (!bus_drive && bus_out == '0));

    // R10
    ctl_release_chk: assert property (@(posedge clk) disable iff (rst)
        rd_oe_n |-> (!ctl_drive && ctl_out == '0));

endmodule

// File: tb/cpu_status_flags_test.sv
module cpu_status_flags_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst;
    logic       bus_all_n, alu_wr_n, flag_wr_n, bus_nz_n, bus_oe_n, rd_oe_n, flag_val;
    logic [7:0] ctl_in, alu_flags, bus_in;
    logic [7:0] ctl_out, bus_out;
    logic       ctl_drive, bus_drive;

    cpu_status_flags uut (
        .clk(clk), .rst(rst), .bus_all_n(bus_all_n), .alu_wr_n(alu_wr_n),
        .flag_wr_n(flag_wr_n), .bus_nz_n(bus_nz_n), .bus_oe_n(bus_oe_n),
        .rd_oe_n(rd_oe_n), .flag_val(flag_val), .ctl_in(ctl_in),
        .alu_flags(alu_flags), .bus_in(bus_in), .ctl_out(ctl_out),
        .ctl_drive(ctl_drive), .bus_out(bus_out), .bus_drive(bus_drive)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] m;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Requirement-level model of the next register value (R2..R8).
    function automatic logic [7:0] model(input logic [7:0] cur);
        logic [7:0] r;
        if (!bus_all_n)      r = bus_in;
        else if (!alu_wr_n)  r = (alu_flags & ctl_in) | (cur & ~ctl_in);
        else if (!flag_wr_n) r = flag_val ? (cur | ctl_in) : (cur & ~ctl_in);
        else if (!bus_nz_n)  r = (cur & 8'h7D) | {bus_in[7], 5'b0, (bus_in == 8'h00), 1'b0};
        else                 r = cur;
        return r & 8'hDF;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        bus_all_n = 1'b1; alu_wr_n = 1'b1; flag_wr_n = 1'b1; bus_nz_n = 1'b1;
    endtask

    task automatic step(input string req);
        m = model(m);
        tick();
        chk(req, bus_out, m);
    endtask

    task automatic preload(input logic [7:0] v);
        idle();
        bus_all_n = 1'b0;
        bus_in = v;
        step("R6");
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL timeout (all requirements) actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] masks [5] = '{8'h03, 8'h82, 8'h83, 8'hC2, 8'hC3};
        rst = 1'b1; idle(); bus_oe_n = 1'b1; rd_oe_n = 1'b1; flag_val = 1'b0;
        ctl_in = '0; alu_flags = '0; bus_in = '0;
        tick(); tick();
        // R1 reset value through the read path
        rd_oe_n = 1'b0; #1;
        chk("R1", ctl_out, 8'h04);
        chk("R10", {7'b0, ctl_drive}, 8'h01);
        chk("R9", bus_out, 8'h00);
        chk("R9", {7'b0, bus_drive}, 8'h00);
        rd_oe_n = 1'b1; #1;
        chk("R10", ctl_out, 8'h00);
        chk("R10", {7'b0, ctl_drive}, 8'h00);
        rst = 1'b0; m = 8'h04;
        bus_oe_n = 1'b0; #1;
        chk("R9", {7'b0, bus_drive}, 8'h01);

        // R6 / R2: every bus byte, bit 5 dropped
        for (int v = 0; v < 256; v++) begin
            idle(); bus_all_n = 1'b0; bus_in = 8'(v);
            step(v[5] ? "R2" : "R6");
        end
        // R5: every bus byte
        for (int v = 0; v < 256; v++) begin
            idle(); bus_nz_n = 1'b0; bus_in = 8'(v);
            step("R5");
        end
        // R3: each mask against every ALU pattern, base is the complement
        for (int k = 0; k < 5; k++) begin
            for (int a = 0; a < 256; a++) begin
                preload(~8'(a));
                alu_wr_n = 1'b0; ctl_in = masks[k]; alu_flags = 8'(a);
                step("R3");
            end
        end
        // R4: every flag, both values, from empty and full bases
        for (int b = 0; b < 8; b++) begin
            if (b == 5) continue;
            for (int val = 0; val < 2; val++) begin
                for (int base = 0; base < 2; base++) begin
                    preload(base == 0 ? 8'h00 : 8'hDF);
                    flag_wr_n = 1'b0; ctl_in = 8'(1 << b); flag_val = val[0];
                    step("R4");
                end
            end
        end
        // R7: all strobe combinations
        for (int s = 0; s < 16; s++) begin
            preload(8'h06);
            bus_in = 8'h81; ctl_in = 8'hC3; alu_flags = 8'h40; flag_val = 1'b1;
            {bus_all_n, alu_wr_n, flag_wr_n, bus_nz_n} = 4'(s);
            step("R7");
        end
        // R7 flag-write over bus-NZ with a one-hot select
        preload(8'h00);
        ctl_in = 8'h08; flag_val = 1'b1; bus_in = 8'h00;
        flag_wr_n = 1'b0; bus_nz_n = 1'b0;
        step("R7");
        // R8: idle with busy inputs
        preload(8'h9B);
        ctl_in = 8'hFF; alu_flags = 8'hFF; flag_val = 1'b1; bus_in = 8'h00;
        for (int i = 0; i < 3; i++) step("R8");
        // R11: same-cycle read returns old value
        preload(8'h11);
        rd_oe_n = 1'b0; bus_all_n = 1'b0; bus_in = 8'hC0; #1;
        chk("R11", ctl_out, 8'h11);
        tick();
        chk("R11", ctl_out, 8'hC0);
        m = 8'hC0;
        idle(); rd_oe_n = 1'b1;
        // R9 release
        bus_oe_n = 1'b1; #1;
        chk("R9", bus_out, 8'h00);
        chk("R9", {7'b0, bus_drive}, 8'h00);
        // R1 reset mid-run
        rst = 1'b1; tick(); rst = 1'b0;
        rd_oe_n = 1'b0; #1;
        chk("R1", ctl_out, 8'h04);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule